// File: doc/BRIEF.md
# DMA Channel Register File

This block is the register file that software uses to program a multi-channel DMA engine. Each channel has four registers that describe one transfer: a start address, a row length, a row count and a control word. Each channel also has a stride (width) register. A group of shared registers collects interrupt state, interrupt enables and loop (cyclic) enables. The address generators sit outside the block. They read the programmed values from output buses, receive one-cycle start and halt pulses, and report per-channel done and half-buffer events back into the status register.

Software uses a simple 32-bit word read/write port. A write is taken on the clock edge where `bus_wr` is high. A read is requested by holding `bus_rd` high across an edge, and the data appears on `bus_rdata` after that edge. It then stays there until the next read. Writing a channel's address register launches that channel. The block combines enabled status bits into a single interrupt line. The channel count `NCH` may be set from 2 to 16.

Top module: `dma_regfile`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `ch_start`, `ch_halt` and `ch_loop` are low.
- R2: Channel n's registers sit at byte offset n*0x10. The address is at +0x0 and holds 32 bits. The row length is at +0x4 and the row count is at +0x8; each of these keeps the low 16 bits of the written value. Written values appear on the channel's output buses after the write edge and read back one edge after `bus_rd`.
- R3: Channel n's control word is at n*0x10+0xC. Bits 3:0 hold a channel tag. Bit 4 set selects four-word bursts (`ch_burst4`). Bit 5 set selects memory-to-device direction (`ch_mem2dev`), and clear selects device-to-memory. All other bits read zero.
- R4: Channel n's width register is at 0x100 + n*4 and keeps the low 16 bits of the written value, which drive `ch_width`.
- R5: A write to channel n's address register makes `ch_start[n]` high for exactly the one cycle after the write edge. Writes to any other register raise no start.
- R6: Writing a word with bit n set to offset 0x140 makes `ch_halt[n]` high for the one cycle after the write edge. Offset 0x140 reads zero.
- R7: The status register at 0x144 has bit n set by `evt_done[n]` or `evt_half[n]`, whatever the enable bit. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: If an event and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R9: The interrupt enable register at 0x148 is read/write. Writing ones to 0x14C clears only those enable bits.
- R10: `irq` is high exactly when some channel has both its status bit and its enable bit set. It follows the register values without an extra cycle.
- R11: The loop register at 0x150 is read/write on bits n and n+16. `ch_loop[n]` is high only when both bits are set. Writing ones to 0x15C clears those bits. Clearing both bits pauses a channel, and setting both again resumes it.
- R12: Reads of unmapped or misaligned offsets return zero, including the clear aliases 0x14C and 0x15C. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| evt_done | input | NCH | Per-channel transfer-done event |
| evt_half | input | NCH | Per-channel half-buffer event |
| ch_start | output | NCH | One-cycle launch pulse per channel |
| ch_halt | output | NCH | One-cycle stop pulse per channel |
| ch_addr | output | NCH*32 | Start addresses, channel n at bits n*32 upward |
| ch_rowlen | output | NCH*16 | Row lengths |
| ch_rows | output | NCH*16 | Row counts |
| ch_burst4 | output | NCH | Four-word burst select |
| ch_mem2dev | output | NCH | Direction, 1 = memory to device |
| ch_width | output | NCH*16 | Stride per channel |
| ch_loop | output | NCH | Loop mode active (both loop bits set) |
| irq | output | 1 | Combined interrupt |

## Verification
Assertions check five behaviours on every cycle. Start and halt pulses appear only after the matching write. Channel configuration stays stable when no write targets it. Status bits change only through events or a clearing write, and an event always wins a same-cycle clear. The clear aliases actually drop the bits written, and unmapped reads return zero. The directed scenarios cover the rest: field placement and truncation in each register, exact pulse widths seen at the ports, and the interrupt line following status and enable combinations. They also drive the pause/resume sequence on the paired loop bits and confirm that an unmapped write disturbs no visible state.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;

    parameter int unsigned DATA_W  = 32;
    parameter int unsigned ROW_W   = 16;
    parameter int unsigned WID_W   = 16;
    parameter int unsigned CHID_W  = 4;
    parameter int unsigned CHSEL_W = 4;

    parameter int unsigned CTRL_BURST_BIT = 4;
    parameter int unsigned CTRL_DIR_BIT   = 5;
    parameter int unsigned LOOP_HI_BASE   = 16;

    parameter int unsigned OFS_WIDTH_BASE = 'h100;
    parameter int unsigned OFS_HALT       = 'h140;
    parameter int unsigned OFS_STAT       = 'h144;
    parameter int unsigned OFS_IEN        = 'h148;
    parameter int unsigned OFS_IEN_CLR    = 'h14C;
    parameter int unsigned OFS_LOOP       = 'h150;
    parameter int unsigned OFS_LOOP_CLR   = 'h15C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CH_ADDR,
        SEL_CH_ROWLEN,
        SEL_CH_ROWS,
        SEL_CH_CTRL,
        SEL_WIDTH,
        SEL_HALT,
        SEL_STAT,
        SEL_IEN,
        SEL_IEN_CLR,
        SEL_LOOP,
        SEL_LOOP_CLR
    } sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic [ROW_W-1:0]  rowlen;
        logic [ROW_W-1:0]  rows;
        logic [CHID_W-1:0] chid;
        logic              burst4;
        logic              mem2dev;
        logic [WID_W-1:0]  width;
    } chan_cfg_t;

endpackage

// File: rtl/dmarf_decode.sv
module dmarf_decode
    import dmarf_pkg::*;
#(
    parameter int unsigned NCH    = 16,
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output sel_e               sel_o,
    output logic [CHSEL_W-1:0] ch_o
);

    localparam logic [ADDR_W-1:0] WIN_END  = ADDR_W'(NCH * 16);
    localparam logic [ADDR_W-1:0] WID_BASE = ADDR_W'(OFS_WIDTH_BASE);
    localparam logic [ADDR_W-1:0] WID_END  = ADDR_W'(OFS_WIDTH_BASE + NCH * 4);
    localparam logic [ADDR_W-1:0] A_HALT   = ADDR_W'(OFS_HALT);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFS_IEN);
    localparam logic [ADDR_W-1:0] A_IENC   = ADDR_W'(OFS_IEN_CLR);
    localparam logic [ADDR_W-1:0] A_LOOP   = ADDR_W'(OFS_LOOP);
    localparam logic [ADDR_W-1:0] A_LOOPC  = ADDR_W'(OFS_LOOP_CLR);

    always_comb begin
        sel_o = SEL_NONE;
        ch_o  = '0;
        if (addr_i[1:0] == 2'b00) begin
            if (addr_i < WIN_END) begin
                ch_o = addr_i[7:4];
                case (addr_i[3:2])
                    2'd0:    sel_o = SEL_CH_ADDR;
                    2'd1:    sel_o = SEL_CH_ROWLEN;
                    2'd2:    sel_o = SEL_CH_ROWS;
                    default: sel_o = SEL_CH_CTRL;
                endcase
            end else if (addr_i >= WID_BASE && addr_i < WID_END) begin
                ch_o  = addr_i[5:2];
                sel_o = SEL_WIDTH;
            end else begin
                case (addr_i)
                    A_HALT:  sel_o = SEL_HALT;
                    A_STAT:  sel_o = SEL_STAT;
                    A_IEN:   sel_o = SEL_IEN;
                    A_IENC:  sel_o = SEL_IEN_CLR;
                    A_LOOP:  sel_o = SEL_LOOP;
                    A_LOOPC: sel_o = SEL_LOOP_CLR;
                    default: sel_o = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/dmarf_chan.sv
module dmarf_chan
    import dmarf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  sel_e              sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output chan_cfg_t         cfg_o,
    output logic              start_o
);

    typedef struct packed {
        chan_cfg_t cfg;
        logic      start;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (wr_i) begin
            case (sel_i)
                SEL_CH_ADDR: begin
                    st_d.cfg.addr = wdata_i;
                    st_d.start    = 1'b1;
                end
                SEL_CH_ROWLEN: st_d.cfg.rowlen = wdata_i[ROW_W-1:0];
                SEL_CH_ROWS:   st_d.cfg.rows   = wdata_i[ROW_W-1:0];
                SEL_CH_CTRL: begin
                    st_d.cfg.chid    = wdata_i[CHID_W-1:0];
                    st_d.cfg.burst4  = wdata_i[CTRL_BURST_BIT];
                    st_d.cfg.mem2dev = wdata_i[CTRL_DIR_BIT];
                end
                SEL_WIDTH:     st_d.cfg.width  = wdata_i[WID_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o   = st_q.cfg;
    assign start_o = st_q.start;

    // R5
    start_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_CH_ADDR) |=> start_o);

    // R5
    no_stray_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel_i == SEL_CH_ADDR) |=> !start_o);

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(cfg_o));

endmodule

// File: rtl/dmarf_shared.sv
module dmarf_shared
    import dmarf_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  sel_e              sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NCH-1:0]    evt_set_i,
    output logic [NCH-1:0]    stat_o,
    output logic [NCH-1:0]    ien_o,
    output logic [DATA_W-1:0] loop_word_o,
    output logic [NCH-1:0]    halt_o,
    output logic [NCH-1:0]    loop_on_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [NCH-1:0] stat;
        logic [NCH-1:0] ien;
        logic [NCH-1:0] loop_lo;
        logic [NCH-1:0] loop_hi;
        logic [NCH-1:0] halt;
    } sh_st_t;

    sh_st_t st_d, st_q;

    logic [NCH-1:0] w_lo, w_hi;
    assign w_lo = wdata_i[NCH-1:0];
    assign w_hi = wdata_i[LOOP_HI_BASE +: NCH];

    always_comb begin
        st_d      = st_q;
        st_d.halt = '0;
        if (wr_i) begin
            case (sel_i)
                SEL_HALT:    st_d.halt = w_lo;
                SEL_STAT:    st_d.stat = st_q.stat & ~w_lo;
                SEL_IEN:     st_d.ien  = w_lo;
                SEL_IEN_CLR: st_d.ien  = st_q.ien & ~w_lo;
                SEL_LOOP: begin
                    st_d.loop_lo = w_lo;
                    st_d.loop_hi = w_hi;
                end
                SEL_LOOP_CLR: begin
                    st_d.loop_lo = st_q.loop_lo & ~w_lo;
                    st_d.loop_hi = st_q.loop_hi & ~w_hi;
                end
                default: ;
            endcase
        end
        st_d.stat = st_d.stat | evt_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        loop_word_o                     = '0;
        loop_word_o[NCH-1:0]            = st_q.loop_lo;
        loop_word_o[LOOP_HI_BASE +: NCH] = st_q.loop_hi;
    end

    assign stat_o    = st_q.stat;
    assign ien_o     = st_q.ien;
    assign halt_o    = st_q.halt;
    assign loop_on_o = st_q.loop_lo & st_q.loop_hi;
    assign irq_o     = |(st_q.stat & st_q.ien);

    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set_i) |=> ((stat_o & $past(evt_set_i)) == $past(evt_set_i)));

    // R7
    stat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_i && sel_i == SEL_STAT) && evt_set_i == '0) |=> (stat_o == $past(stat_o)));

    // R9
    ien_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_IEN_CLR) |=> ((ien_o & $past(w_lo)) == '0));

    // R11
    loop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_LOOP_CLR && (w_lo & w_hi) != '0) |=> ((loop_on_o & $past(w_lo & w_hi)) == '0));

    // R6
    halt_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel_i == SEL_HALT) |=> (halt_o == '0));

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dmarf_pkg::*;
#(
    parameter int unsigned NCH    = 16,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NCH-1:0]        evt_done,
    input  logic [NCH-1:0]        evt_half,
    output logic [NCH-1:0]        ch_start,
    output logic [NCH-1:0]        ch_halt,
    output logic [NCH*DATA_W-1:0] ch_addr,
    output logic [NCH*ROW_W-1:0]  ch_rowlen,
    output logic [NCH*ROW_W-1:0]  ch_rows,
    output logic [NCH-1:0]        ch_burst4,
    output logic [NCH-1:0]        ch_mem2dev,
    output logic [NCH*WID_W-1:0]  ch_width,
    output logic [NCH-1:0]        ch_loop,
    output logic                  irq
);

    localparam int unsigned CHX_W = $clog2(NCH);

    sel_e                sel;
    logic [CHSEL_W-1:0]  ch_idx;
    logic [CHX_W-1:0]    ci;
    chan_cfg_t           cfg [NCH];
    logic [NCH-1:0]      stat, ien;
    logic [DATA_W-1:0]   loop_word;

    assign ci = ch_idx[CHX_W-1:0];

    dmarf_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr),
        .sel_o  (sel),
        .ch_o   (ch_idx)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic chan_wr;
        assign chan_wr = bus_wr && (ch_idx == CHSEL_W'(i));

        dmarf_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (chan_wr),
            .sel_i   (sel),
            .wdata_i (bus_wdata),
            .cfg_o   (cfg[i]),
            .start_o (ch_start[i])
        );

        assign ch_addr[i*DATA_W +: DATA_W] = cfg[i].addr;
        assign ch_rowlen[i*ROW_W +: ROW_W] = cfg[i].rowlen;
        assign ch_rows[i*ROW_W +: ROW_W]   = cfg[i].rows;
        assign ch_width[i*WID_W +: WID_W]  = cfg[i].width;
        assign ch_burst4[i]                = cfg[i].burst4;
        assign ch_mem2dev[i]               = cfg[i].mem2dev;
    end

    dmarf_shared #(.NCH(NCH)) u_shared (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (bus_wr),
        .sel_i       (sel),
        .wdata_i     (bus_wdata),
        .evt_set_i   (evt_done | evt_half),
        .stat_o      (stat),
        .ien_o       (ien),
        .loop_word_o (loop_word),
        .halt_o      (ch_halt),
        .loop_on_o   (ch_loop),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) begin
            rd_d.rdata = '0;
            case (sel)
                SEL_CH_ADDR:   rd_d.rdata = cfg[ci].addr;
                SEL_CH_ROWLEN: rd_d.rdata[ROW_W-1:0] = cfg[ci].rowlen;
                SEL_CH_ROWS:   rd_d.rdata[ROW_W-1:0] = cfg[ci].rows;
                SEL_CH_CTRL: begin
                    rd_d.rdata[CHID_W-1:0]     = cfg[ci].chid;
                    rd_d.rdata[CTRL_BURST_BIT] = cfg[ci].burst4;
                    rd_d.rdata[CTRL_DIR_BIT]   = cfg[ci].mem2dev;
                end
                SEL_WIDTH:     rd_d.rdata[WID_W-1:0] = cfg[ci].width;
                SEL_STAT:      rd_d.rdata[NCH-1:0]   = stat;
                SEL_IEN:       rd_d.rdata[NCH-1:0]   = ien;
                SEL_LOOP:      rd_d.rdata            = loop_word;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    // R12
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;

    localparam int NCH = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    evt_done = '0;
    logic [NCH-1:0]    evt_half = '0;
    logic [NCH-1:0]    ch_start, ch_halt, ch_burst4, ch_mem2dev, ch_loop;
    logic [NCH*32-1:0] ch_addr;
    logic [NCH*16-1:0] ch_rowlen, ch_rows, ch_width;
    logic              irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_done(evt_done), .evt_half(evt_half), .ch_start(ch_start),
        .ch_halt(ch_halt), .ch_addr(ch_addr), .ch_rowlen(ch_rowlen),
        .ch_rows(ch_rows), .ch_burst4(ch_burst4), .ch_mem2dev(ch_mem2dev),
        .ch_width(ch_width), .ch_loop(ch_loop), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse_evt(input logic [NCH-1:0] dn, input logic [NCH-1:0] hf);
        evt_done = dn; evt_half = hf;
        @(negedge clk);
        evt_done = '0; evt_half = '0;
    endtask

    task automatic t_reset;
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 start", {16'b0, ch_start}, 0);
        check("R1 loop", {16'b0, ch_loop}, 0);
        rd_check("R1 stat", 12'h144, 0);
        rd_check("R1 ch0 addr", 12'h000, 0);
        rd_check("R1 loopreg", 12'h150, 0);
    endtask

    task automatic t_chan_regs;
        wr(12'h030, 32'hDEAD_BEEF);
        wr(12'h034, 32'hABCD_1234);
        wr(12'h038, 32'h0000_0077);
        rd_check("R2 ch3 addr", 12'h030, 32'hDEAD_BEEF);
        rd_check("R2 ch3 rowlen", 12'h034, 32'h0000_1234);
        rd_check("R2 ch3 rows", 12'h038, 32'h0000_0077);
        check("R2 ch3 addr out", ch_addr[3*32 +: 32], 32'hDEAD_BEEF);
        check("R2 ch3 rowlen out", {16'b0, ch_rowlen[3*16 +: 16]}, 32'h1234);
        wr(12'h0F0, 32'h1357_9BDF);
        rd_check("R2 ch15 addr", 12'h0F0, 32'h1357_9BDF);
        rd_check("R2 ch2 addr untouched", 12'h020, 0);
    endtask

    task automatic t_ctrl;
        wr(12'h05C, 32'hFFFF_FF35);
        rd_check("R3 ctrl mask", 12'h05C, 32'h35);
        check("R3 burst4", {31'b0, ch_burst4[5]}, 1);
        check("R3 mem2dev", {31'b0, ch_mem2dev[5]}, 1);
        wr(12'h05C, 32'h0000_001F);
        rd_check("R3 ctrl tag", 12'h05C, 32'h1F);
        check("R3 dev2mem", {31'b0, ch_mem2dev[5]}, 0);
        check("R3 other ch", {16'b0, ch_burst4}, 32'h20);
    endtask

    task automatic t_width;
        wr(12'h11C, 32'h0001_2345);
        rd_check("R4 width ch7", 12'h11C, 32'h2345);
        check("R4 width out", {16'b0, ch_width[7*16 +: 16]}, 32'h2345);
        check("R4 no start", {16'b0, ch_start}, 0);
    endtask

    task automatic t_start;
        wr(12'h090, 32'h0000_1000);
        check("R5 start pulse", {16'b0, ch_start}, 32'h200);
        @(negedge clk);
        check("R5 start width", {16'b0, ch_start}, 0);
        wr(12'h094, 32'h10);
        check("R5 rowlen no start", {16'b0, ch_start}, 0);
    endtask

    task automatic t_halt;
        wr(12'h140, 32'h0000_8001);
        check("R6 halt pulse", {16'b0, ch_halt}, 32'h8001);
        @(negedge clk);
        check("R6 halt width", {16'b0, ch_halt}, 0);
        rd_check("R6 halt reads zero", 12'h140, 0);
    endtask

    task automatic t_status;
        pulse_evt(16'h0004, 16'h0040);
        rd_check("R7 events set", 12'h144, 32'h44);
        check("R7 irq masked", {31'b0, irq}, 0);
        wr(12'h144, 32'h0);
        rd_check("R7 zero write", 12'h144, 32'h44);
        wr(12'h144, 32'h4);
        rd_check("R7 w1c", 12'h144, 32'h40);
    endtask

    task automatic t_race;
        evt_half = 16'h0040;
        bus_wr = 1'b1; bus_addr = 12'h144; bus_wdata = 32'h40;
        @(negedge clk);
        bus_wr = 1'b0; evt_half = '0;
        rd_check("R8 event wins", 12'h144, 32'h40);
    endtask

    task automatic t_enable;
        wr(12'h148, 32'h0000_F0F0);
        rd_check("R9 enable rw", 12'h148, 32'hF0F0);
        wr(12'h14C, 32'h0000_0030);
        rd_check("R9 enable clr", 12'h148, 32'hF0C0);
    endtask

    task automatic t_irq;
        check("R10 irq on", {31'b0, irq}, 1);
        wr(12'h144, 32'h40);
        check("R10 irq off", {31'b0, irq}, 0);
        pulse_evt(16'h0001, 16'h0000);
        check("R10 masked event", {31'b0, irq}, 0);
        wr(12'h148, 32'h0000_F0C1);
        check("R10 enable raises", {31'b0, irq}, 1);
        wr(12'h14C, 32'h1);
        check("R10 clr alias drops", {31'b0, irq}, 0);
    endtask

    task automatic t_loop;
        wr(12'h150, 32'h0004_0004);
        check("R11 both bits", {16'b0, ch_loop}, 32'h4);
        wr(12'h150, 32'h0008_0000);
        check("R11 one bit", {16'b0, ch_loop}, 0);
        rd_check("R11 readback", 12'h150, 32'h0008_0000);
        wr(12'h150, 32'h0003_0003);
        wr(12'h15C, 32'h0001_0000);
        check("R11 clr hi", {16'b0, ch_loop}, 32'h2);
        rd_check("R11 clr readback", 12'h150, 32'h0002_0003);
        wr(12'h15C, 32'h0002_0002);
        check("R11 pause", {16'b0, ch_loop}, 32'h0);
        wr(12'h150, 32'h0002_0002);
        check("R11 resume", {16'b0, ch_loop}, 32'h2);
    endtask

    task automatic t_unmapped;
        rd_check("R12 ien clr alias", 12'h14C, 0);
        rd_check("R12 loop clr alias", 12'h15C, 0);
        rd_check("R12 gap", 12'h154, 0);
        rd_check("R12 misaligned", 12'h146, 0);
        rd_check("R12 high", 12'h200, 0);
        wr(12'h200, 32'hFFFF_FFFF);
        wr(12'h14A, 32'hFFFF_FFFF);
        rd_check("R12 stat kept", 12'h144, 32'h1);
        rd_check("R12 ien kept", 12'h148, 32'hF0C0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chan_regs();
        t_ctrl();
        t_width();
        t_start();
        t_halt();
        t_status();
        t_race();
        t_enable();
        t_irq();
        t_loop();
        t_unmapped();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule